// File: doc/BRIEF.md
# Multiplexed Keypad Scan Port

This block is an 8-bit memory-mapped port through which software reads eleven handheld buttons. The buttons fall into three groups: a four-key X pad, a four-key Y pad and a three-key group holding start, A and B. Software writes group-select bits into the upper half of the port. A later read returns that upper half unchanged, with the four key levels of the selected group in the lower half. The key inputs arrive already debounced and active high. A snapshot register captures them every clock, so one read always sees a coherent set of keys.

An orientation input swaps which physical pad feeds the X and Y groups. Each single-cycle pulse on it flips the orientation. The ordinary reset does not clear this orientation. Only the power-on reset does. The port is reached through a write strobe with 8-bit write data and a read strobe. The read data is registered and holds its value between reads.

Top module: `keypad_scan_port`

## Requirements
- R1: While `rst` is high, the stored upper half, the key snapshot and `rdata` all clear to zero. After release, `rdata` reads 0x00 until the first read.
- R2: A cycle with `wr_en` high stores `wdata[7:4]` as the select nibble. The low half of the port is never writable: `wdata[3:0]` has no effect on any later read.
- R3: A read (`rd_en` high at a clock edge) drives `rdata[7:4]` from the stored select nibble as it was before that edge. This holds for every select value.
- R4: When select bit 6 is set, `rdata[3:0]` is {B, A, start, 0}: start in bit 1, A in bit 2, B in bit 3, and bit 0 reads zero.
- R5: When bit 6 is clear and bit 5 is set, `rdata[3:0]` carries the X group, with X1..X4 in bits 0..3.
- R6: When bits 6 and 5 are clear and bit 4 is set, `rdata[3:0]` carries the Y group, with Y1..Y4 in bits 0..3.
- R7: When bits 6, 5 and 4 are all clear, `rdata[3:0]` reads zero whatever keys are pressed.
- R8: Key levels are captured at every edge. A read issued at the edge after a key change reports the new level. `rdata` keeps its value in cycles without a read.
- R9: Each cycle with `swap_pulse` high flips the orientation. While flipped, the X group reads the `pad_b` pins and the Y group reads the `pad_a` pins. Unflipped, X reads `pad_a` and Y reads `pad_b`.
- R10: The orientation survives `rst`. Only `por` returns it to unflipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; also clears orientation |
| rst | input | 1 | Port reset, synchronous, active high; keeps orientation |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data; bits 7:4 are kept |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| key_start | input | 1 | Start button level |
| key_a | input | 1 | A button level |
| key_b | input | 1 | B button level |
| pad_a | input | 4 | First four-key pad, bit i is key i+1 |
| pad_b | input | 4 | Second four-key pad, bit i is key i+1 |
| swap_pulse | input | 1 | One-cycle pulse that flips pad orientation |

## Verification
A key change needs one edge to reach the snapshot, and the read needs one more edge to reach `rdata`. The bench therefore changes keys, issues the read at the next edge, and compares the result half a cycle after the read edge. A write reaches the select nibble one edge after it is issued, so the following read already reflects it. An orientation pulse needs two edges before a read sees swapped groups, so the bench waits one idle cycle after each pulse. Expected bytes are queued when a read is issued and compared by a monitor at the falling edge after the read edge.

// File: rtl/kp_pkg.sv
package kp_pkg;

    localparam int BUS_W = 8;
    localparam int GRP_W = 4;
    localparam int HI_W  = BUS_W - GRP_W;

    // select bit positions, in priority order
    localparam int SEL_BTN = 6;
    localparam int SEL_X   = 5;
    localparam int SEL_Y   = 4;

    localparam logic [BUS_W-1:0] HI_MASK = {{HI_W{1'b1}}, {GRP_W{1'b0}}};

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_BTN  = 2'd1,
        GRP_X    = 2'd2,
        GRP_Y    = 2'd3
    } grp_sel_t;

    typedef struct packed {
        logic             start;
        logic             a;
        logic             b;
        logic [GRP_W-1:0] x;
        logic [GRP_W-1:0] y;
    } key_snap_t;

    function automatic grp_sel_t decode_group(input logic [BUS_W-1:0] hi);
        if (hi[SEL_BTN])     return GRP_BTN;
        else if (hi[SEL_X])  return GRP_X;
        else if (hi[SEL_Y])  return GRP_Y;
        else                 return GRP_NONE;
    endfunction

    function automatic logic [GRP_W-1:0] group_bits(input grp_sel_t g, input key_snap_t k);
        logic [GRP_W-1:0] v;
        v = '0;
        case (g)
            GRP_BTN: begin
                v[1] = k.start;
                v[2] = k.a;
                v[3] = k.b;
            end
            GRP_X:   v = k.x;
            GRP_Y:   v = k.y;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/kp_orient.sv
module kp_orient (
    input  logic clk,
    input  logic por,
    input  logic swap_pulse,
    output logic flip
);
    always_ff @(posedge clk) begin
        if (por)
            flip <= 1'b0;
        else if (swap_pulse)
            flip <= ~flip;
    end
endmodule

// File: rtl/kp_sampler.sv
module kp_sampler
    import kp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flip,
    input  logic             key_start,
    input  logic             key_a,
    input  logic             key_b,
    input  logic [GRP_W-1:0] pad_a,
    input  logic [GRP_W-1:0] pad_b,
    output key_snap_t        snap
);
    key_snap_t snap_d;

    always_comb begin
        snap_d.start = key_start;
        snap_d.a     = key_a;
        snap_d.b     = key_b;
        snap_d.x     = flip ? pad_b : pad_a;
        snap_d.y     = flip ? pad_a : pad_b;
    end

    always_ff @(posedge clk) begin
        if (rst)
            snap <= '0;
        else
            snap <= snap_d;
    end
endmodule

// File: rtl/kp_hi_reg.sv
module kp_hi_reg
    import kp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] port_hi
);
    always_ff @(posedge clk) begin
        if (rst)
            port_hi <= '0;
        else if (wr_en)
            port_hi <= wdata & HI_MASK;
    end
endmodule

// File: rtl/keypad_scan_port.sv
module keypad_scan_port
    import kp_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    input  logic             rd_en,
    output logic [BUS_W-1:0] rdata,
    input  logic             key_start,
    input  logic             key_a,
    input  logic             key_b,
    input  logic [GRP_W-1:0] pad_a,
    input  logic [GRP_W-1:0] pad_b,
    input  logic             swap_pulse
);
    logic             flip;
    key_snap_t        snap;
    logic [BUS_W-1:0] port_hi;
    grp_sel_t         grp;
    logic [GRP_W-1:0] low_bits;
    logic [BUS_W-1:0] rdata_d;

    kp_orient u_orient (
        .clk        (clk),
        .por        (por),
        .swap_pulse (swap_pulse),
        .flip       (flip)
    );

    kp_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .flip      (flip),
        .key_start (key_start),
        .key_a     (key_a),
        .key_b     (key_b),
        .pad_a     (pad_a),
        .pad_b     (pad_b),
        .snap      (snap)
    );

    kp_hi_reg u_hi (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .port_hi (port_hi)
    );

    always_comb begin
        grp      = decode_group(port_hi);
        low_bits = group_bits(grp, snap);
        rdata_d  = port_hi | {{HI_W{1'b0}}, low_bits};
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rdata_d;
    end
endmodule

// File: rtl/kp_scan_chk.sv
module kp_scan_chk
    import kp_pkg::*;
(
    input logic             clk,
    input logic             por,
    input logic             rst,
    input logic             wr_en,
    input logic [BUS_W-1:0] wdata,
    input logic             rd_en,
    input logic [BUS_W-1:0] rdata,
    input logic [BUS_W-1:0] port_hi,
    input logic             swap_pulse,
    input logic             flip
);
    // R2
    hi_write_chk: assert property (@(posedge clk) disable iff (rst || por)
        wr_en |=> port_hi == ($past(wdata) & HI_MASK));

    // R2
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst || por)
        !wr_en |=> $stable(port_hi));

    // R3
    hi_echo_chk: assert property (@(posedge clk) disable iff (rst || por)
        rd_en |=> rdata[BUS_W-1:GRP_W] == $past(port_hi[BUS_W-1:GRP_W]));

    // R4
    btn_bit0_chk: assert property (@(posedge clk) disable iff (rst || por)
        (rd_en && port_hi[SEL_BTN]) |=> !rdata[0]);

    // R7
    no_sel_chk: assert property (@(posedge clk) disable iff (rst || por)
        (rd_en && port_hi[SEL_BTN:SEL_Y] == 3'b000) |=> rdata[GRP_W-1:0] == '0);

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst || por)
        !rd_en |=> $stable(rdata));

    // R9
    flip_toggle_chk: assert property (@(posedge clk) disable iff (por)
        swap_pulse |=> flip != $past(flip));

    // R10
    flip_keep_chk: assert property (@(posedge clk) disable iff (por)
        !swap_pulse |=> $stable(flip));

    // R1
    always @(posedge clk) begin
        if (!por && !rst && $past(rst)) begin
            rst_clear_chk: assert (rdata == '0 && port_hi == '0);
        end
    end
endmodule

bind keypad_scan_port kp_scan_chk u_chk (
    .clk        (clk),
    .por        (por),
    .rst        (rst),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .port_hi    (port_hi),
    .swap_pulse (swap_pulse),
    .flip       (flip)
);

// File: tb/tb_keypad_scan_port.sv
module tb_keypad_scan_port;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       key_start = 1'b0;
    logic       key_a = 1'b0;
    logic       key_b = 1'b0;
    logic [3:0] pad_a = 4'h0;
    logic [3:0] pad_b = 4'h0;
    logic       swap_pulse = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // bench model
    logic [3:0] m_hi = 4'h0;
    bit         m_flip = 1'b0;

    keypad_scan_port dut (
        .clk        (clk),
        .por        (por),
        .rst        (rst),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .rd_en      (rd_en),
        .rdata      (rdata),
        .key_start  (key_start),
        .key_a      (key_a),
        .key_b      (key_b),
        .pad_a      (pad_a),
        .pad_b      (pad_b),
        .swap_pulse (swap_pulse)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] model_read();
        logic [3:0] lo;
        logic [3:0] xg;
        logic [3:0] yg;
        xg = m_flip ? pad_b : pad_a;
        yg = m_flip ? pad_a : pad_b;
        if (m_hi[2])      lo = {key_b, key_a, key_start, 1'b0};
        else if (m_hi[1]) lo = xg;
        else if (m_hi[0]) lo = yg;
        else              lo = 4'h0;
        return {m_hi, lo};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_hi  = v[7:4];
    endtask

    task automatic do_read(input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        exp_q.push_back(model_read());
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_swap();
        @(negedge clk);
        swap_pulse = 1'b1;
        @(negedge clk);
        swap_pulse = 1'b0;
        m_flip = ~m_flip;
        @(negedge clk);
    endtask

    // monitor: compare at the falling edge after each read edge
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("monitor underrun", rdata, 8'hxx);
                end else begin
                    check(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        por = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata after reset", rdata, 8'h00);
        do_read("R1 first read no select");

        // R6 / R5 / R4 / R3
        pad_a = 4'b1010; pad_b = 4'b0110;
        key_start = 1'b1; key_a = 1'b0; key_b = 1'b1;
        do_write(8'h10);
        do_read("R6 Y group");
        do_write(8'h20);
        do_read("R5 X group");
        do_write(8'h40);
        do_read("R4 button group");
        do_write(8'h70);
        do_read("R4 bit6 priority over 5 and 4");
        do_write(8'h30);
        do_read("R5 bit5 priority over 4");
        do_write(8'h80);
        do_read("R7 only bit7 set reads zero low");
        do_write(8'hF0);
        key_start = 1'b0; key_a = 1'b1; key_b = 1'b0;
        do_read("R3 all ones upper echo");

        // R2: low nibble not writable
        pad_a = 4'h0;
        do_write(8'hAF);
        do_read("R2 low nibble not writable");
        do_write(8'h0F);
        do_read("R7 no select with write of low ones");

        // R8: key change visible on next read, rdata holds
        do_write(8'h20);
        pad_a = 4'b0001;
        do_read("R8 X after change a");
        pad_a = 4'b1000;
        do_read("R8 X after change b");
        held = rdata;
        pad_a = 4'b0111;
        repeat (3) @(negedge clk);
        check("R8 rdata holds without read", rdata, held);

        // R9: swap orientation
        pad_a = 4'b0011; pad_b = 4'b1100;
        do_swap();
        do_read("R9 X from second pad when flipped");
        do_write(8'h10);
        do_read("R9 Y from first pad when flipped");

        // R10: flip survives rst
        @(negedge clk);
        rst = 1'b1;
        m_hi = 4'h0;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rdata after second reset", rdata, 8'h00);
        do_write(8'h20);
        do_read("R10 flip kept across rst");
        do_swap();
        do_read("R9 second pulse unflips");

        do_swap();
        @(negedge clk);
        por = 1'b1;
        rst = 1'b1;
        m_hi = 4'h0;
        m_flip = 1'b0;
        @(negedge clk);
        por = 1'b0;
        rst = 1'b0;
        do_write(8'h20);
        do_read("R10 por clears flip");

        repeat (3) @(negedge clk);
        check("R8 queue drained", {7'd0, exp_q.size() != 0}, 8'h00);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule